// File: doc/BRIEF.md
# HDSL Interrupt Aggregation and Status Unit

This block collects the interrupt events of a three-channel HDSL transceiver and presents them to a processor through a byte-wide register port. Each channel's receive 6 ms frame-start strobe sets its own pending bit. Two transmit error sources (stuffing and transmit FIFO) and five receive error sources (framer state change, receive FIFO, CRC counter overflow, FEBE counter overflow and DPLL error) each set a sticky status bit. Enabled status bits are folded into one transmit summary and one receive summary bit. A single active-high `irq` output is raised whenever a pending bit is also set in the mask register.

The block also keeps a snapshot of the 16-bit DPLL residual. The snapshot is taken in the same cycle as the frame strobe of the channel chosen as master by `master_sel`, and software reads it as two bytes. The register port is plain control logic with no back-pressure. A write takes effect at the clock edge on which `reg_wr` is sampled high. Read data is combinational from `reg_addr` while `reg_rd` is high, and any read side effect takes place at that same edge.

Top module: `hdsl_irq_status`

## Requirements
- R1: A high bit in `rx_frame_start` sets the matching pending bit in the request register (address 0x2C). Bit 0 is channel 1, bit 1 is channel 2 and bit 2 is channel 3.
- R2: A read of 0x2C clears the three frame pending bits after the read data has been returned. A strobe that arrives in the same cycle as that read leaves its bit set.
- R3: Each error status bit at 0x3C is set by its source pulse whatever the enables hold. Writing a 1 to a bit at 0x3C clears it. A pulse in the same cycle as the clear wins. Bit 0 is TX stuffing, bit 1 TX FIFO, bit 2 framer, bit 3 RX FIFO, bit 4 CRC overflow, bit 5 FEBE overflow and bit 6 DPLL.
- R4: Bit 3 of 0x2C (transmit summary) is the OR of status bits 0 and 1, each ANDed with the same bit of the error enable register (read/write at 0x3D).
- R5: Bit 4 of 0x2C (receive summary) is the OR of status bits 2 to 6, each ANDed with its enable bit at 0x3D.
- R6: The 5-bit mask is written at 0xEB. Address 0x30 reads back the same value with bits 7:5 at zero.
- R7: `irq` is high exactly when some bit of 0x2C[4:0] is set and the same mask bit is set.
- R8: `resid_in` is captured only at a strobe of the master channel. `master_sel` values 0 and 1 select channel 1, 2 selects channel 2 and 3 selects channel 3.
- R9: 0x28 returns snapshot bits 7:0, and the read also holds bits 15:8. 0x20 returns the held upper byte, so a read of 0x28 followed by 0x20 always gives halves from one snapshot.
- R10: After reset, every register reads zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_frame_start | input | 3 | Per-channel receive frame-start strobes |
| tx_err_pulse | input | 2 | Transmit error pulses: stuffing, FIFO |
| rx_err_pulse | input | 5 | Receive error pulses: framer, FIFO, CRC ovf, FEBE ovf, DPLL |
| resid_in | input | 16 | Live DPLL residual value |
| master_sel | input | 2 | Master channel select for the snapshot |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its defaults: three channels, two transmit sources, five receive sources and a 16-bit residual. These values make every `master_sel` code reachable, including code 3, which selects the last channel, and code 0, which aliases to channel 1. They also let each summary bit be driven by an enabled source and then masked by a disabled one. Collisions are driven on purpose: a frame strobe during the request-register read, and an error pulse during its own write-to-clear. A new snapshot is also taken between the two byte reads of the residual.

// File: rtl/hdsl_irq_pkg.sv
package hdsl_irq_pkg;
  localparam logic [7:0] A_IRR      = 8'h2C;
  localparam logic [7:0] A_ERR_STAT = 8'h3C;
  localparam logic [7:0] A_ERR_EN   = 8'h3D;
  localparam logic [7:0] A_MASK_WR  = 8'hEB;
  localparam logic [7:0] A_MASK_RB  = 8'h30;
  localparam logic [7:0] A_RES_LO   = 8'h28;
  localparam logic [7:0] A_RES_HI   = 8'h20;
endpackage

// File: rtl/err_sticky_bank.sv
module err_sticky_bank #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_pulse,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] status
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                     status[i] <= 1'b0;
      else if (set_pulse[i])          status[i] <= 1'b1;
      else if (clr_en && clr_bits[i]) status[i] <= 1'b0;
    end

    assert_err_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      set_pulse[i] |=> status[i]);
    assert_err_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i] && !(clr_en && clr_bits[i])) |=> status[i]);
  end
endmodule

// File: rtl/frame_pend_reg.sv
module frame_pend_reg #(
  parameter int N_CH = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] strobe,
  input  logic            rd_clr,
  output logic [N_CH-1:0] pend
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)         pend[c] <= 1'b0;
      else if (strobe[c]) pend[c] <= 1'b1;
      else if (rd_clr)    pend[c] <= 1'b0;
    end

    assert_frame_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      strobe[c] |=> pend[c]);
    assert_frame_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !strobe[c]) |=> !pend[c]);
  end
endmodule

// File: rtl/resid_snapshot.sv
module resid_snapshot #(
  parameter int N_CH    = 3,
  parameter int RESID_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CH-1:0]    strobe,
  input  logic [1:0]         sel,
  input  logic [RESID_W-1:0] resid_in,
  input  logic               lo_rd,
  output logic [RESID_W-1:0] snap,
  output logic [RESID_W-9:0] hi_hold
);
  logic [1:0] idx;
  logic       master_hit;

  always_comb begin
    idx = (sel == 2'd0) ? 2'd0 : sel - 2'd1;
    if (int'(idx) >= N_CH) idx = 2'd0;
    master_hit = strobe[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap    <= '0;
      hi_hold <= '0;
    end else begin
      if (master_hit) snap <= resid_in;
      if (lo_rd)      hi_hold <= snap[RESID_W-1:8];
    end
  end

  assert_snap_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    master_hit |=> (snap == $past(resid_in)));
  assert_snap_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !master_hit |=> $stable(snap));
  assert_hi_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_rd |=> $stable(hi_hold));
endmodule

// File: rtl/hdsl_irq_status.sv
module hdsl_irq_status
  import hdsl_irq_pkg::*;
#(
  parameter int N_CH    = 3,
  parameter int N_TXE   = 2,
  parameter int N_RXE   = 5,
  parameter int RESID_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CH-1:0]    rx_frame_start,
  input  logic [N_TXE-1:0]   tx_err_pulse,
  input  logic [N_RXE-1:0]   rx_err_pulse,
  input  logic [RESID_W-1:0] resid_in,
  input  logic [1:0]         master_sel,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [7:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic               irq
);
  localparam int ERR_W = N_TXE + N_RXE;
  localparam int IRR_W = N_CH + 2;

  logic [ERR_W-1:0]   err_stat, err_en_q;
  logic [N_CH-1:0]    frame_pend;
  logic [IRR_W-1:0]   irr_bits, mask_q;
  logic [RESID_W-1:0] snap;
  logic [RESID_W-9:0] hi_hold;
  logic               tx_sum, rx_sum;
  logic               wr_stat, rd_irr, rd_lo;

  assign wr_stat = reg_wr && (reg_addr == A_ERR_STAT);
  assign rd_irr  = reg_rd && (reg_addr == A_IRR);
  assign rd_lo   = reg_rd && (reg_addr == A_RES_LO);

  err_sticky_bank #(.W(ERR_W)) u_err (
    .clk(clk), .rst_n(rst_n),
    .set_pulse({rx_err_pulse, tx_err_pulse}),
    .clr_en(wr_stat), .clr_bits(reg_wdata[ERR_W-1:0]),
    .status(err_stat)
  );

  frame_pend_reg #(.N_CH(N_CH)) u_frame (
    .clk(clk), .rst_n(rst_n), .strobe(rx_frame_start),
    .rd_clr(rd_irr), .pend(frame_pend)
  );

  resid_snapshot #(.N_CH(N_CH), .RESID_W(RESID_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .strobe(rx_frame_start), .sel(master_sel),
    .resid_in(resid_in), .lo_rd(rd_lo), .snap(snap), .hi_hold(hi_hold)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_en_q <= '0;
      mask_q   <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_ERR_EN)  err_en_q <= reg_wdata[ERR_W-1:0];
      if (reg_addr == A_MASK_WR) mask_q   <= reg_wdata[IRR_W-1:0];
    end
  end

  always_comb begin
    tx_sum   = |(err_stat[N_TXE-1:0] & err_en_q[N_TXE-1:0]);
    rx_sum   = |(err_stat[ERR_W-1:N_TXE] & err_en_q[ERR_W-1:N_TXE]);
    irr_bits = {rx_sum, tx_sum, frame_pend};
    irq      = |(irr_bits & mask_q);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        A_IRR:      reg_rdata[IRR_W-1:0] = irr_bits;
        A_ERR_STAT: reg_rdata[ERR_W-1:0] = err_stat;
        A_ERR_EN:   reg_rdata[ERR_W-1:0] = err_en_q;
        A_MASK_RB:  reg_rdata[IRR_W-1:0] = mask_q;
        A_RES_LO:   reg_rdata = snap[7:0];
        A_RES_HI:   reg_rdata = hi_hold[7:0];
        default:    reg_rdata = '0;
      endcase
    end
  end

  assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_MASK_WR) |=> (mask_q == $past(reg_wdata[IRR_W-1:0])));
  assert_en_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_ERR_EN) |=> $stable(err_en_q));
  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
endmodule

// File: tb/hdsl_irq_status_bench.sv
module hdsl_irq_status_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  rx_frame_start = '0;
  logic [1:0]  tx_err_pulse = '0;
  logic [4:0]  rx_err_pulse = '0;
  logic [15:0] resid_in = '0;
  logic [1:0]  master_sel = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0, reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  hdsl_irq_status u_hdsl_irq_status (
    .clk(clk), .rst_n(rst_n), .rx_frame_start(rx_frame_start),
    .tx_err_pulse(tx_err_pulse), .rx_err_pulse(rx_err_pulse),
    .resid_in(resid_in), .master_sel(master_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic frame(input logic [2:0] s);
    @(negedge clk); rx_frame_start = s;
    @(negedge clk); rx_frame_start = '0;
  endtask

  task automatic errp(input logic [1:0] t, input logic [4:0] r);
    @(negedge clk); tx_err_pulse = t; rx_err_pulse = r;
    @(negedge clk); tx_err_pulse = '0; rx_err_pulse = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R10 irq", 16'(irq), 16'h0);
    rd(8'h2C, d); chk("R10 irr", 16'(d), 16'h00);
    rd(8'h3C, d); chk("R10 errstat", 16'(d), 16'h00);
    rd(8'h30, d); chk("R10 mask", 16'(d), 16'h00);
    rd(8'h28, d); chk("R10 res lo", 16'(d), 16'h00);
  endtask

  task automatic t_frames();
    logic [7:0] d;
    frame(3'b001);
    rd(8'h2C, d); chk("R1 ch1 pend", 16'(d), 16'h01);
    rd(8'h2C, d); chk("R2 cleared", 16'(d), 16'h00);
    frame(3'b100);
    rd(8'h2C, d); chk("R1 ch3 pend", 16'(d), 16'h04);
    @(negedge clk); reg_rd = 1; reg_addr = 8'h2C; rx_frame_start = 3'b010;
    #1 d = reg_rdata; chk("R2 collide read", 16'(d), 16'h00);
    @(negedge clk); reg_rd = 0; rx_frame_start = '0;
    rd(8'h2C, d); chk("R2 strobe survives", 16'(d), 16'h02);
  endtask

  task automatic t_errors();
    logic [7:0] d;
    errp(2'b01, 5'b00100);
    rd(8'h3C, d); chk("R3 sticky set", 16'(d), 16'h11);
    rd(8'h2C, d); chk("R4 R5 disabled", 16'(d), 16'h00);
    wr(8'h3D, 8'h01);
    rd(8'h2C, d); chk("R4 tx summary", 16'(d), 16'h08);
    wr(8'h3D, 8'h12);
    rd(8'h2C, d); chk("R5 rx summary", 16'(d), 16'h10);
    wr(8'h3D, 8'h6E);
    rd(8'h2C, d); chk("R5 other rx enabled only", 16'(d), 16'h00);
    wr(8'h3D, 8'h7F);
    rd(8'h3D, d); chk("R4 enable readback", 16'(d), 16'h7F);
    wr(8'h3C, 8'h01);
    rd(8'h3C, d); chk("R3 w1c", 16'(d), 16'h10);
    @(negedge clk); reg_wr = 1; reg_addr = 8'h3C; reg_wdata = 8'h10; rx_err_pulse = 5'b00100;
    @(negedge clk); reg_wr = 0; rx_err_pulse = '0;
    rd(8'h3C, d); chk("R3 pulse beats clear", 16'(d), 16'h10);
    wr(8'h3C, 8'h7F);
    rd(8'h3C, d); chk("R3 all cleared", 16'(d), 16'h00);
    wr(8'h3D, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(8'hEB, 8'hAA);
    rd(8'h30, d); chk("R6 mask readback", 16'(d), 16'h0A);
    wr(8'hEB, 8'h00);
    frame(3'b001);
    chk("R7 masked off", 16'(irq), 16'h0);
    wr(8'hEB, 8'h02);
    chk("R7 other bit", 16'(irq), 16'h0);
    wr(8'hEB, 8'h01);
    chk("R7 irq raised", 16'(irq), 16'h1);
    rd(8'h2C, d);
    chk("R7 irq drops after clear", 16'(irq), 16'h0);
    wr(8'hEB, 8'h00);
  endtask

  task automatic t_resid();
    logic [7:0] d;
    logic [7:0] e;
    master_sel = 2'd0; resid_in = 16'h1234;
    frame(3'b010);
    rd(8'h28, d); chk("R8 non-master ignored", 16'(d), 16'h00);
    frame(3'b001);
    rd(8'h28, d); chk("R8 sel0 lo", 16'(d), 16'h34);
    rd(8'h20, d); chk("R9 sel0 hi", 16'(d), 16'h12);
    master_sel = 2'd2; resid_in = 16'hABCD;
    frame(3'b010);
    rd(8'h28, d); chk("R8 sel2 lo", 16'(d), 16'hCD);
    master_sel = 2'd3; resid_in = 16'h5566;
    frame(3'b011);
    rd(8'h28, d); chk("R8 sel3 ignores ch1 ch2", 16'(d), 16'hCD);
    frame(3'b100);
    rd(8'h28, d); chk("R8 sel3 lo", 16'(d), 16'h66);
    resid_in = 16'h9911;
    frame(3'b100);
    rd(8'h20, e); chk("R9 hi held from old snapshot", 16'(e), 16'h55);
    rd(8'h28, d); chk("R9 new lo", 16'(d), 16'h11);
    rd(8'h20, d); chk("R9 new hi", 16'(d), 16'h99);
    rd(8'h2C, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_frames();
    t_errors();
    t_mask();
    t_resid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule